// File: doc/BRIEF.md
# I2C Master Transmit Engine with Status Codes

This block is the transmit half of an I2C bus master that software steers one bus event at a time. Software loads a byte into the data register and writes a control register that holds four bits: a start request, a stop request, an event flag and an acknowledge-enable bit. The engine forms START, repeated START and STOP conditions, shifts out address and data bytes MSB first, samples the acknowledge bit and watches SDA for arbitration loss. SCL and SDA are open-drain: the engine only ever pulls a line low, and it reads the wired-AND level back from the bus.

After each event the engine sets the event flag, posts a fixed hexadecimal status code and keeps SCL low, so the bus waits for software. Software writes the next byte and then writes the control register with the event flag at 0. The start and stop bits written at that moment select the next action. When the flag is clear, or when no event is pending, the status output reads F8h. The acknowledge-enable bit has no effect on any transmit action. SCL timing comes from a divider of the system clock. Each bit is split into four quarter periods of `QUARTER` clocks, and the engine waits for SCL to read high before it ends the high phase, which honours clock stretching by a slave.

Top module: `i2c_mtx`

## Requirements
- R1: After reset the status reads F8h, the event flag, start bit, stop bit and receive-mode flag are 0, and neither bus line is pulled low.
- R2: A control write with the start bit (bit 3) set and the event flag (bit 1) at 0 on a free bus produces a START (SDA falls while SCL is high), then status 08h with the event flag set and the start bit cleared by hardware.
- R3: While the event flag is set with any status other than 38h, the engine holds SCL low. Writing 1 to the event flag does not change it; only writing 0 clears it.
- R4: After a START or repeated START, clearing the event flag with start and stop at 0 sends the data register MSB first as the address byte, then samples the ninth bit: 18h if SDA was low (ACK), 20h if it was high (NACK).
- R5: After status 18h, 20h, 28h or 30h, clearing the event flag with start and stop at 0 sends the data register as a data byte and posts 28h on ACK or 30h on NACK.
- R6: After a byte status, a control write with start=1 and stop=0 sends a repeated START and posts 10h.
- R7: After a byte status, a control write with start=0 and stop=1 sends a STOP (SDA rises while SCL is high). Hardware then clears the stop bit, leaves the event flag clear with status F8h and releases both lines.
- R8: After a byte status, a control write with start=1 and stop=1 sends a STOP and then a START, and posts 08h.
- R9: If the byte to be sent after a START or repeated START has bit 0 set (read address), the engine sends nothing, raises the receive-mode flag for good and keeps SCL low with the event flag clear.
- R10: When SDA reads low at a rising SCL while the engine is leaving SDA high during an address or data bit, the engine releases both lines and posts 38h. Clearing the flag with start=0 leaves the bus untouched and the engine idle.
- R11: Clearing the 38h flag with start=1 queues a START that is sent only after a STOP has been seen on the bus, and then posts 08h.
- R12: When a slave holds SCL low, the engine waits and finishes the byte correctly once SCL is released.
- R13: Apart from START and STOP, SDA changes only while SCL is low, so the bus shows exactly the ordered sequence of conditions and bytes that the control writes asked for.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 data register, 1 control register |
| wrVal | input | 8 | Write value; control bits: 3 start, 2 stop, 1 event flag, 0 acknowledge enable |
| sclIn | input | 1 | SCL level read from the bus |
| sdaIn | input | 1 | SDA level read from the bus |
| statusCode | output | 8 | Status code, F8h when no event is pending |
| siFlag | output | 1 | Event flag; SCL is held while set |
| staFlag | output | 1 | Start request bit |
| stoFlag | output | 1 | Stop request bit |
| rxMode | output | 1 | Sticky flag: a read address was loaded after a START |
| sclDriveLow | output | 1 | Pull SCL low when 1 |
| sdaDriveLow | output | 1 | Pull SDA low when 1 |

## Verification
The bench targets the action combinations written while a byte status is pending. An engine that decodes start together with stop wrongly would show a stray or missing START or STOP in the observed bus sequence. Arbitration is lost once with start=0 and once with start=1. A design that does not defer the queued START would pull SDA low while another master still holds the bus, and one that forgets the request would never post 08h. A slave stretches SCL in the middle of a byte, which catches a divider that runs on without reading SCL back, since that engine would shift a bit too early and corrupt the byte. A read address after a START checks that the engine parks with nothing on the bus rather than clocking the byte out.

// File: rtl/i2c_mtx_pkg.sv
package i2c_mtx_pkg;

  localparam logic [7:0] CODE_IDLE   = 8'hF8;
  localparam logic [7:0] CODE_START  = 8'h08;
  localparam logic [7:0] CODE_RSTART = 8'h10;
  localparam logic [7:0] CODE_AACK   = 8'h18;
  localparam logic [7:0] CODE_ANACK  = 8'h20;
  localparam logic [7:0] CODE_DACK   = 8'h28;
  localparam logic [7:0] CODE_DNACK  = 8'h30;
  localparam logic [7:0] CODE_LOST   = 8'h38;

  // control register bit positions
  localparam int BIT_STA = 3;
  localparam int BIT_STO = 2;
  localparam int BIT_SI  = 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_RSTART, ST_BIT, ST_STOP, ST_WAIT, ST_PARK
  } state_t;

  typedef enum logic [1:0] {CTX_ADDR, CTX_XFER, CTX_LOST} ctx_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       loadShift;
    logic       shiftNext;
    logic       postEn;
    logic       clrSta;
    logic       clrSto;
    logic       setRx;
    logic [7:0] postCode;
  } strobe_t;

endpackage

// File: rtl/i2c_mtx_dp.sv
module i2c_mtx_dp
  import i2c_mtx_pkg::*;
#(
  parameter int QUARTER = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrSel,
  input  logic [7:0] wrVal,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  strobe_t    stb,
  output logic       tick,
  output logic       staFlag,
  output logic       stoFlag,
  output logic       siFlag,
  output logic       rxMode,
  output logic       txMsb,
  output logic       addrRead,
  output logic       busBusy,
  output logic [7:0] statusCode
);

  localparam int CW = (QUARTER > 2) ? $clog2(QUARTER) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUARTER - 1);

  logic [CW-1:0] divCnt;
  logic [7:0]    dataReg;
  logic [7:0]    shiftReg;
  logic [7:0]    codeReg;
  logic          sclQ;
  logic          sdaQ;
  logic          ctrlWr;

  assign tick       = (divCnt == LAST);
  assign ctrlWr     = wrEn && wrSel;
  assign txMsb      = shiftReg[7];
  assign addrRead   = dataReg[0];
  assign statusCode = siFlag ? codeReg : CODE_IDLE;

  // quarter-bit divider
  always_ff @(posedge clk) begin
    if (!rstN)     divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + 1'b1;
  end

  // data and shift registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg  <= '0;
      shiftReg <= '0;
    end else begin
      if (wrEn && !wrSel) dataReg <= wrVal;
      if (stb.loadShift)      shiftReg <= dataReg;
      else if (stb.shiftNext) shiftReg <= {shiftReg[6:0], 1'b0};
    end
  end

  // control bits, event flag and posted code
  always_ff @(posedge clk) begin
    if (!rstN) begin
      staFlag <= 1'b0;
      stoFlag <= 1'b0;
      siFlag  <= 1'b0;
      rxMode  <= 1'b0;
      codeReg <= CODE_IDLE;
    end else begin
      if (ctrlWr)          staFlag <= wrVal[BIT_STA];
      else if (stb.clrSta) staFlag <= 1'b0;
      if (ctrlWr)          stoFlag <= wrVal[BIT_STO];
      else if (stb.clrSto) stoFlag <= 1'b0;
      if (stb.postEn)                     siFlag <= 1'b1;
      else if (ctrlWr && !wrVal[BIT_SI])  siFlag <= 1'b0;
      if (stb.postEn) codeReg <= stb.postCode;
      if (stb.setRx)  rxMode  <= 1'b1;
    end
  end

  // bus busy monitor: START sets, STOP clears
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
      busBusy <= 1'b0;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
      if (sclIn && sclQ && sdaQ && !sdaIn)      busBusy <= 1'b1;
      else if (sclIn && sclQ && !sdaQ && sdaIn) busBusy <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_mtx_ctl.sv
module i2c_mtx_ctl
  import i2c_mtx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    tick,
  input  logic    sclIn,
  input  logic    sdaIn,
  input  logic    staFlag,
  input  logic    stoFlag,
  input  logic    siFlag,
  input  logic    txMsb,
  input  logic    addrRead,
  input  logic    busBusy,
  output strobe_t stb,
  output logic    sclDriveLow,
  output logic    sdaDriveLow
);

  state_t     state, nState;
  ctx_t       ctx, nCtx;
  logic [1:0] q, nQ;
  logic [3:0] bitIdx, nBit;
  logic       sclLow, nScl, sdaLow, nSda;
  logic       isAddr, nAddr, ackOk, nAck;

  assign sclDriveLow = sclLow;
  assign sdaDriveLow = sdaLow;

  always_comb begin
    nState = state; nCtx = ctx; nQ = q; nBit = bitIdx;
    nScl = sclLow; nSda = sdaLow; nAddr = isAddr; nAck = ackOk;
    stb = '0;
    unique case (state)
      ST_IDLE: if (tick && staFlag && !busBusy && sclIn && sdaIn) begin
        nState = ST_START; nQ = 2'd0;
      end
      ST_START: if (tick) begin
        if (q == 2'd0) begin
          nSda = 1'b1; nQ = 2'd1;
        end else begin
          nScl = 1'b1; nState = ST_WAIT; nCtx = CTX_ADDR;
          stb.postEn = 1'b1; stb.postCode = CODE_START; stb.clrSta = 1'b1;
        end
      end
      ST_WAIT: if (!siFlag) begin
        unique case (ctx)
          CTX_ADDR: if (addrRead) begin
            stb.setRx = 1'b1; nState = ST_PARK;
          end else begin
            stb.loadShift = 1'b1; nAddr = 1'b1; nBit = '0; nQ = 2'd0; nState = ST_BIT;
          end
          CTX_XFER: if (stoFlag) begin
            nState = ST_STOP; nQ = 2'd0;
          end else if (staFlag) begin
            nState = ST_RSTART; nQ = 2'd0;
          end else begin
            stb.loadShift = 1'b1; nAddr = 1'b0; nBit = '0; nQ = 2'd0; nState = ST_BIT;
          end
          default: nState = ST_IDLE;
        endcase
      end
      ST_BIT: if (tick) begin
        unique case (q)
          2'd0: begin
            nSda = (bitIdx < 4'd8) && !txMsb; nQ = 2'd1;
          end
          2'd1: begin
            nScl = 1'b0; nQ = 2'd2;
          end
          2'd2: if (sclIn) begin
            if (bitIdx < 4'd8 && !sdaLow && !sdaIn) begin
              nScl = 1'b0; nSda = 1'b0; nState = ST_WAIT; nCtx = CTX_LOST;
              stb.postEn = 1'b1; stb.postCode = CODE_LOST;
            end else begin
              if (bitIdx == 4'd8) nAck = !sdaIn;
              nQ = 2'd3;
            end
          end
          default: begin
            nScl = 1'b1;
            if (bitIdx == 4'd8) begin
              nState = ST_WAIT; nCtx = CTX_XFER; stb.postEn = 1'b1;
              if (isAddr) stb.postCode = ackOk ? CODE_AACK : CODE_ANACK;
              else        stb.postCode = ackOk ? CODE_DACK : CODE_DNACK;
            end else begin
              stb.shiftNext = 1'b1; nBit = bitIdx + 4'd1; nQ = 2'd0;
            end
          end
        endcase
      end
      ST_RSTART: if (tick) begin
        unique case (q)
          2'd0: begin nSda = 1'b0; nQ = 2'd1; end
          2'd1: begin nScl = 1'b0; nQ = 2'd2; end
          2'd2: if (sclIn) begin nSda = 1'b1; nQ = 2'd3; end
          default: begin
            nScl = 1'b1; nState = ST_WAIT; nCtx = CTX_ADDR;
            stb.postEn = 1'b1; stb.postCode = CODE_RSTART; stb.clrSta = 1'b1;
          end
        endcase
      end
      ST_STOP: if (tick) begin
        unique case (q)
          2'd0: begin nSda = 1'b1; nQ = 2'd1; end
          2'd1: begin nScl = 1'b0; nQ = 2'd2; end
          default: if (sclIn) begin
            nSda = 1'b0; stb.clrSto = 1'b1; nState = ST_IDLE;
          end
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE; ctx <= CTX_ADDR; q <= '0; bitIdx <= '0;
      sclLow <= 1'b0; sdaLow <= 1'b0; isAddr <= 1'b0; ackOk <= 1'b0;
    end else begin
      state <= nState; ctx <= nCtx; q <= nQ; bitIdx <= nBit;
      sclLow <= nScl; sdaLow <= nSda; isAddr <= nAddr; ackOk <= nAck;
    end
  end

endmodule

// File: rtl/i2c_mtx.sv
module i2c_mtx
  import i2c_mtx_pkg::*;
#(
  parameter int QUARTER = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrSel,
  input  logic [7:0] wrVal,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic [7:0] statusCode,
  output logic       siFlag,
  output logic       staFlag,
  output logic       stoFlag,
  output logic       rxMode,
  output logic       sclDriveLow,
  output logic       sdaDriveLow
);

  strobe_t stb;
  logic    tick, txMsb, addrRead, busBusy;

  i2c_mtx_dp #(.QUARTER(QUARTER)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrVal(wrVal),
    .sclIn(sclIn), .sdaIn(sdaIn), .stb(stb), .tick(tick),
    .staFlag(staFlag), .stoFlag(stoFlag), .siFlag(siFlag), .rxMode(rxMode),
    .txMsb(txMsb), .addrRead(addrRead), .busBusy(busBusy), .statusCode(statusCode)
  );

  i2c_mtx_ctl u_ctl (
    .clk(clk), .rstN(rstN), .tick(tick), .sclIn(sclIn), .sdaIn(sdaIn),
    .staFlag(staFlag), .stoFlag(stoFlag), .siFlag(siFlag), .txMsb(txMsb),
    .addrRead(addrRead), .busBusy(busBusy), .stb(stb),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow)
  );

endmodule

// File: rtl/i2c_mtx_chk.sv
module i2c_mtx_chk (
  input logic       clk,
  input logic       rstN,
  input logic       siFlag,
  input logic       rxMode,
  input logic       sclDriveLow,
  input logic       sdaDriveLow,
  input logic [7:0] statusCode
);

  // R3
  si_holds_scl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (siFlag && statusCode != 8'h38) |-> sclDriveLow);

  // R2 R4 R5 R6 R10: a raised flag always carries a defined event code
  post_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(siFlag) |-> (statusCode inside {8'h08, 8'h10, 8'h18, 8'h20, 8'h28, 8'h30, 8'h38}));

  // R10
  lost_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(siFlag) && statusCode == 8'h38) |-> (!sclDriveLow && !sdaDriveLow));

  // R9
  rx_park_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxMode |=> (rxMode && !siFlag && sclDriveLow));

endmodule

bind i2c_mtx i2c_mtx_chk u_chk (
  .clk(clk), .rstN(rstN), .siFlag(siFlag), .rxMode(rxMode),
  .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow), .statusCode(statusCode)
);

// File: tb/test_i2c_mtx.sv
`timescale 1ns/1ps
module test_i2c_mtx;

  localparam logic [1:0] EV_BYTE = 2'd0, EV_START = 2'd1, EV_STOP = 2'd2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0, wrSel = 1'b0;
  logic [7:0] wrVal = '0;
  logic [7:0] statusCode;
  logic       siFlag, staFlag, stoFlag, rxMode, sclDriveLow, sdaDriveLow;
  logic       slaveLow, rivalLow;
  int         stretchCnt;
  logic       scl, sda;

  logic ackNext = 1'b1;
  logic stretchEn = 1'b0;
  logic rivalEn = 1'b0;
  int   rivalAt = 0;
  int   nVec = 0, nBad = 0;
  logic done = 1'b0;
  logic [9:0] expQ[$];

  always #5 clk = ~clk;

  assign scl = !(sclDriveLow || (stretchCnt != 0));
  assign sda = !(sdaDriveLow || slaveLow || rivalLow);

  i2c_mtx i_i2c_mtx (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrVal(wrVal),
    .sclIn(scl), .sdaIn(sda), .statusCode(statusCode), .siFlag(siFlag),
    .staFlag(staFlag), .stoFlag(stoFlag), .rxMode(rxMode),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // scoreboard compare, R13
  task automatic seen(input logic [1:0] kind, input logic [7:0] val);
    logic [9:0] e;
    nVec++;
    if (expQ.size() == 0) begin
      nBad++;
      $display("FAIL R13 bus event act=%h exp=none", {kind, val});
    end else begin
      e = expQ.pop_front();
      if (e !== {kind, val}) begin
        nBad++;
        $display("FAIL R13 bus event act=%h exp=%h", {kind, val}, e);
      end
    end
  endtask

  task automatic push(input logic [1:0] kind, input logic [7:0] val);
    expQ.push_back({kind, val});
  endtask

  // bus monitor with slave, stretcher and rival master
  logic       prevScl, prevSda;
  logic [7:0] acc;
  int         bitCnt;
  always @(negedge clk) begin
    logic s, d;
    s = scl; d = sda;
    if (!rstN) begin
      prevScl = 1'b1; prevSda = 1'b1; bitCnt = 0; acc = '0;
      slaveLow = 1'b0; rivalLow = 1'b0; stretchCnt = 0;
    end else begin
      if (!rivalEn) rivalLow = 1'b0;
      if (stretchCnt > 0) stretchCnt--;
      if (s && prevScl && prevSda && !d) begin
        seen(EV_START, 8'h00); bitCnt = 0;
      end else if (s && prevScl && !prevSda && d) begin
        seen(EV_STOP, 8'h00); bitCnt = 0;
      end else if (!prevScl && s) begin
        if (bitCnt < 8) acc = {acc[6:0], d};
        bitCnt++;
      end else if (prevScl && !s) begin
        if (bitCnt == 8) begin
          seen(EV_BYTE, acc); slaveLow = ackNext;
        end else if (bitCnt == 9) begin
          slaveLow = 1'b0; bitCnt = 0;
        end
        if (stretchEn && bitCnt == 3) stretchCnt = 30;
        if (rivalEn && bitCnt == rivalAt) rivalLow = 1'b1;
      end
      prevScl = s; prevSda = d;
    end
  end

  task automatic wrReg(input logic sel, input logic [7:0] val);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrVal = val;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitSi(input string tag);
    for (int i = 0; i < 3000; i++) begin
      if (siFlag) break;
      @(negedge clk);
    end
    if (!siFlag) begin
      nBad++; nVec++;
      $display("FAIL %s event flag act=0 exp=1", tag);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b, input logic ack, input logic [7:0] code, input string tag);
    ackNext = ack;
    wrReg(1'b0, b);
    push(EV_BYTE, b);
    wrReg(1'b1, 8'h00);
    waitSi(tag);
    chk(tag, statusCode, code);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++; nVec++;
    $display("FAIL watchdog act=running exp=finished");
    finishRun();
  end

  initial begin
    idle(5);
    rstN = 1'b1;
    idle(2);
    // R1 reset state
    chk("R1 status", statusCode, 8'hF8);
    chk("R1 flags", {4'b0, siFlag, staFlag, stoFlag, rxMode}, 8'h00);
    chk("R1 drives", {6'b0, sclDriveLow, sdaDriveLow}, 8'h00);

    // R2 START on a free bus
    wrReg(1'b0, 8'hA4);
    push(EV_START, 8'h00);
    wrReg(1'b1, 8'h08);
    waitSi("R2");
    chk("R2 status", statusCode, 8'h08);
    chk("R2 start bit cleared", {7'b0, staFlag}, 8'h00);

    // R3 SCL held while the flag is set; writing 1 keeps it
    idle(40);
    chk("R3 scl held", {6'b0, sclDriveLow, scl}, 8'h02);
    wrReg(1'b1, 8'h02);
    idle(20);
    chk("R3 write one keeps flag", {7'b0, siFlag}, 8'h01);
    chk("R3 status kept", statusCode, 8'h08);

    // R4 address ACK, R5 data ACK with R12 stretch, R5 data NACK
    sendByte(8'hA4, 1'b1, 8'h18, "R4 addr ack");
    stretchEn = 1'b1;
    wrReg(1'b0, 8'h3C);
    push(EV_BYTE, 8'h3C);
    wrReg(1'b1, 8'h01);
    idle(2);
    chk("R12 F8 while busy", statusCode, 8'hF8);
    waitSi("R12");
    stretchEn = 1'b0;
    chk("R12 stretched byte status", statusCode, 8'h28);
    sendByte(8'hFF, 1'b0, 8'h30, "R5 data nack");

    // R6 repeated START, then R4 address NACK
    push(EV_START, 8'h00);
    wrReg(1'b1, 8'h08);
    waitSi("R6");
    chk("R6 status", statusCode, 8'h10);
    sendByte(8'hA6, 1'b0, 8'h20, "R4 addr nack");

    // R7 STOP
    push(EV_STOP, 8'h00);
    wrReg(1'b1, 8'h04);
    idle(200);
    chk("R7 stop bit cleared", {7'b0, stoFlag}, 8'h00);
    chk("R7 status", statusCode, 8'hF8);
    chk("R7 lines released", {5'b0, siFlag, sclDriveLow, sdaDriveLow}, 8'h00);

    // R8 STOP then START
    push(EV_START, 8'h00);
    wrReg(1'b1, 8'h08);
    waitSi("R2 again");
    sendByte(8'h90, 1'b1, 8'h18, "R4 addr ack 2");
    push(EV_STOP, 8'h00);
    push(EV_START, 8'h00);
    wrReg(1'b1, 8'h0C);
    waitSi("R8");
    chk("R8 status", statusCode, 8'h08);
    chk("R8 stop bit cleared", {7'b0, stoFlag}, 8'h00);

    // R10 arbitration loss, no queued START
    sendByte(8'h5A, 1'b1, 8'h18, "R4 addr ack 3");
    rivalAt = 2; rivalEn = 1'b1;
    wrReg(1'b0, 8'hFF);
    wrReg(1'b1, 8'h00);
    waitSi("R10");
    chk("R10 status", statusCode, 8'h38);
    chk("R10 released", {6'b0, sclDriveLow, sdaDriveLow}, 8'h00);
    wrReg(1'b1, 8'h00);
    idle(100);
    chk("R10 stays idle", {7'b0, siFlag}, 8'h00);
    chk("R10 status idle", statusCode, 8'hF8);
    push(EV_STOP, 8'h00);
    rivalEn = 1'b0;
    idle(20);

    // R11 arbitration loss with queued START
    push(EV_START, 8'h00);
    wrReg(1'b1, 8'h08);
    waitSi("R2 third");
    sendByte(8'h5A, 1'b1, 8'h18, "R4 addr ack 4");
    rivalAt = 1; rivalEn = 1'b1;
    wrReg(1'b0, 8'hF0);
    wrReg(1'b1, 8'h00);
    waitSi("R10 second");
    chk("R10 status second", statusCode, 8'h38);
    wrReg(1'b1, 8'h08);
    idle(100);
    chk("R11 start deferred", {6'b0, siFlag, sdaDriveLow}, 8'h00);
    push(EV_STOP, 8'h00);
    push(EV_START, 8'h00);
    rivalEn = 1'b0;
    waitSi("R11");
    chk("R11 status", statusCode, 8'h08);

    // R9 read address parks the engine
    wrReg(1'b0, 8'hA1);
    wrReg(1'b1, 8'h00);
    idle(300);
    chk("R9 receive flag", {7'b0, rxMode}, 8'h01);
    chk("R9 parked", {6'b0, siFlag, sclDriveLow}, 8'h01);

    // R13 every expected bus event was seen
    chk("R13 events left", 8'(expQ.size()), 8'h00);
    finishRun();
  end

endmodule